// File: doc/BRIEF.md
# SMBus Indexed Configuration Register Target

This block is an SMBus target that holds a nine-byte configuration register file. It runs on a system clock. It oversamples SCL and SDA through a synchroniser and finds the bit edges and the start and stop conditions internally. It pulls SDA low through an open-drain enable and never stretches SCL. Its own 7-bit address comes from two three-level strap inputs, so up to nine targets can share one bus segment.

A host writes configuration with an indexed block write: a start index, then a byte count, then that many data bytes. A host reads configuration with an indexed block read. The host writes the start index, issues a repeated start and sends the read address. The target then returns a length byte taken from a writable count register, followed by register bytes from the index upward, until the host answers a byte with NACK. The register contents are available in parallel on `cfg_q`. Some fields mirror live readback inputs.

Top module: `smb_cfg_target`

## Requirements
- R1: Each strap input is coded 00 = low, 01 = mid, 10 = high; 11 is treated as high. The 8-bit write-address byte (read address = that value + 1) is selected by (strap_a1, strap_a0) as follows: low/low D8, low/mid DA, low/high DE, mid/low C2, mid/mid C4, mid/high C6, high/low CA, high/mid CC, high/high CE (hex).
- R2: An address byte whose upper seven bits do not match the strap address is not acknowledged. The target then keeps SDA released for every later bit until the next start condition.
- R3: In a block write, the target ACKs the address, the index byte N and the count byte X. It then ACKs X data bytes and stores them at indices N, N+1, ... N+X-1, one index per byte.
- R4: Data bytes sent after the X counted bytes of a block write are not acknowledged and change no register. SDA stays released until the next start.
- R5: A block read proceeds as follows. The host writes index N, issues a repeated start and sends the read address. The target ACKs it, sends the length byte, and then sends the values at indices N, N+1, ... for as long as the host ACKs each byte. Bytes are sent MSB first.
- R6: When the host answers a read byte with NACK, the target stops driving SDA and drives nothing until the next start.
- R7: Bits 4:0 of index 7 are a writable count field with reset value 8. Bits 7:5 read 0. The length byte sent in a read is {000, count field}.
- R8: Index 5 reads 0x31: revision 3 in bits 7:4 and vendor code 1 in bits 3:0. Index 6 reads 0xDB. Writes to either index are ACKed and have no effect.
- R9: Indices 1 and 2 are fully writable and reset to 0xFF. Index 8 always reads 0. Indices 9 and above read 0, and writes to them are ACKed and discarded.
- R10: Index 0 is laid out as follows: bits 7:6 = mode_rb_i[2:1], bit 0 = mode_rb_i[0], bits 5:3 writable with reset 111, bits 2:1 read 0. Index 3 reads pin_rb_i. Index 4 has bits 3:1 writable with reset 000, and its other bits read 0. Byte i of cfg_q (bits 8i+7:8i) equals the value read at index i.
- R11: A synchronous active-high reset restores every register default, returns the bus logic to idle and releases SDA, even in the middle of a transfer.
- R12: The SDA drive changes only after a detected SCL falling edge, or when it is released at a start or stop condition. It never changes while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| strap_a1 | input | 2 | Upper address strap level (00 low, 01 mid, 10 high) |
| strap_a0 | input | 2 | Lower address strap level (00 low, 01 mid, 10 high) |
| mode_rb_i | input | 3 | Live readback shown in index 0 bits 7:6 and 0 |
| pin_rb_i | input | 8 | Live readback shown at index 3 |
| cfg_q | output | 72 | Register file view, byte i = index i |

## Verification
The bench drives bit-level SMBus transfers and keeps a behavioural model of the register file. Whenever the bus is quiet, the model is compared with `cfg_q`. Plain block writes and reads check in-order storage and in-order streaming. Writes that cover read-only, reserved and out-of-range indices separate the write masks from simple storage. A write with more data bytes than its count shows where the target stops acknowledging. A read after the count field is changed shows that the length byte follows the register. All nine strap settings are tried, each also against a neighbouring address, which shows the address decode to be exact and not merely permissive. Changing the readback inputs, and resetting in the middle of a transfer, cover the live fields and the recovery path.

// File: rtl/smb_pkg.sv
package smb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_SKIP
    } bus_st_e;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_INDEX,
        PH_COUNT,
        PH_DATA
    } phase_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_ev_t;

    typedef struct packed {
        logic       en;
        logic [7:0] idx;
        logic [7:0] data;
    } wr_req_t;

    // strap code to rank: 0 low, 1 mid, 2 high (11 folds onto high)
    function automatic logic [1:0] lvl_rank(input logic [1:0] code);
        case (code)
            2'b00:   return 2'd0;
            2'b01:   return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

    // 7-bit target address from the two straps
    function automatic logic [6:0] strap_addr(input logic [1:0] a1, input logic [1:0] a0);
        logic [7:0] wa;
        case ({lvl_rank(a1), lvl_rank(a0)})
            4'h0:    wa = 8'hD8;
            4'h1:    wa = 8'hDA;
            4'h2:    wa = 8'hDE;
            4'h4:    wa = 8'hC2;
            4'h5:    wa = 8'hC4;
            4'h6:    wa = 8'hC6;
            4'h8:    wa = 8'hCA;
            4'h9:    wa = 8'hCC;
            default: wa = 8'hCE;
        endcase
        return wa[7:1];
    endfunction

    // writable bits per index
    function automatic logic [7:0] reg_wmask(input int i);
        case (i)
            0:       return 8'h38;
            1, 2:    return 8'hFF;
            4:       return 8'h0E;
            7:       return 8'h1F;
            default: return 8'h00;
        endcase
    endfunction

    // reset value of the stored bits per index
    function automatic logic [7:0] reg_rst(input int i);
        case (i)
            0:       return 8'h38;
            1, 2:    return 8'hFF;
            7:       return 8'h08;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/smb_edge.sv
module smb_edge
    import smb_pkg::*;
#(
    parameter int SYNC = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    logic [SYNC-1:0] scl_sh, sda_sh;
    logic            scl_d, sda_d;
    logic            scl_s, sda_s;

    assign scl_s = scl_sh[SYNC-1];
    assign sda_s = sda_sh[SYNC-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[SYNC-2:0], scl_i};
            sda_sh <= {sda_sh[SYNC-2:0], sda_i};
            scl_d  <= scl_s;
            sda_d  <= sda_s;
        end
    end

    always_comb begin
        ev.scl_rise = scl_s & ~scl_d;
        ev.scl_fall = ~scl_s & scl_d;
        ev.start    = scl_s & scl_d & sda_d & ~sda_s;
        ev.stop     = scl_s & scl_d & ~sda_d & sda_s;
        ev.sda      = sda_s;
    end
endmodule

// File: rtl/smb_regfile.sv
module smb_regfile
    import smb_pkg::*;
#(
    parameter int         NREG      = 9,
    parameter logic [3:0] VENDOR_ID = 4'h1,
    parameter logic [3:0] REV_ID    = 4'h3,
    parameter logic [7:0] DEV_ID    = 8'hDB
) (
    input  logic              clk,
    input  logic              rst,
    input  wr_req_t           wr,
    input  logic [7:0]        rd_idx,
    output logic [7:0]        rd_data,
    output logic [7:0]        cnt_o,
    input  logic [2:0]        mode_rb_i,
    input  logic [7:0]        pin_rb_i,
    output logic [8*NREG-1:0] cfg_q
);
    localparam int IW = $clog2(NREG);

    logic [NREG-1:0][7:0] store;
    logic [NREG-1:0][7:0] view;

    function automatic logic [7:0] view_of(input int i, input logic [7:0] s,
                                           input logic [2:0] m, input logic [7:0] p);
        case (i)
            0:       return (s & reg_wmask(0)) | {m[2:1], 5'b0, m[0]};
            3:       return p;
            5:       return {REV_ID, VENDOR_ID};
            6:       return DEV_ID;
            default: return s & reg_wmask(i);
        endcase
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) store[i] <= reg_rst(i);
        end else if (wr.en && wr.idx < 8'(NREG)) begin
            store[wr.idx[IW-1:0]] <= (store[wr.idx[IW-1:0]] & ~reg_wmask(int'(wr.idx)))
                                   | (wr.data & reg_wmask(int'(wr.idx)));
        end
    end

    for (genvar g = 0; g < NREG; g++) begin : g_view
        assign view[g] = view_of(g, store[g], mode_rb_i, pin_rb_i);
    end

    assign cfg_q   = view;
    assign rd_data = (rd_idx < 8'(NREG)) ? view[rd_idx[IW-1:0]] : 8'h00;

    if (NREG > 7) begin : g_cnt
        assign cnt_o = {3'b000, store[7][4:0]};

        AST_COUNT_WRITE: assert property (@(posedge clk) disable iff (rst)
            $past(wr.en && wr.idx == 8'd7 && !rst) |-> cnt_o == {3'b000, $past(wr.data[4:0])}); // R7
        AST_RESET_DEFAULTS: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> (cfg_q[15:8] == 8'hFF && cfg_q[23:16] == 8'hFF && cnt_o == 8'h08)); // R11
    end else begin : g_nocnt
        assign cnt_o = 8'h00;
    end

    AST_OOR_DISCARD: assert property (@(posedge clk) disable iff (rst)
        $past(wr.en && wr.idx >= 8'(NREG) && !rst) |-> $stable(store)); // R9
endmodule

// File: rtl/smb_cfg_target.sv
module smb_cfg_target
    import smb_pkg::*;
#(
    parameter int         NREG        = 9,
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] VENDOR_ID   = 4'h1,
    parameter logic [3:0] REV_ID      = 4'h3,
    parameter logic [7:0] DEV_ID      = 8'hDB
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [1:0]        strap_a1,
    input  logic [1:0]        strap_a0,
    input  logic [2:0]        mode_rb_i,
    input  logic [7:0]        pin_rb_i,
    output logic [8*NREG-1:0] cfg_q
);
    bus_ev_t    ev;
    wr_req_t    wr;
    bus_st_e    st;
    phase_e     ph;
    logic [3:0] bcnt;
    logic [7:0] shreg, txb, idx, wrem;
    logic [7:0] rd_data, cnt_byte;
    logic       rd_mode, hack;
    logic [6:0] my_addr;
    logic       rx_ack;

    smb_edge #(.SYNC(SYNC_STAGES)) u_edge (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .ev(ev)
    );

    smb_regfile #(.NREG(NREG), .VENDOR_ID(VENDOR_ID), .REV_ID(REV_ID), .DEV_ID(DEV_ID)) u_regs (
        .clk(clk), .rst(rst), .wr(wr), .rd_idx(idx), .rd_data(rd_data), .cnt_o(cnt_byte),
        .mode_rb_i(mode_rb_i), .pin_rb_i(pin_rb_i), .cfg_q(cfg_q)
    );

    assign my_addr = strap_addr(strap_a1, strap_a0);

    always_comb begin
        case (ph)
            PH_ADDR: rx_ack = (shreg[7:1] == my_addr);
            PH_DATA: rx_ack = (wrem != 8'd0);
            default: rx_ack = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            ph      <= PH_ADDR;
            bcnt    <= '0;
            shreg   <= '0;
            txb     <= '0;
            idx     <= '0;
            wrem    <= '0;
            rd_mode <= 1'b0;
            hack    <= 1'b0;
            sda_oe  <= 1'b0;
            wr      <= '0;
        end else begin
            wr.en <= 1'b0;
            if (ev.stop) begin
                st     <= ST_IDLE;
                sda_oe <= 1'b0;
            end else if (ev.start) begin
                st      <= ST_RX;
                ph      <= PH_ADDR;
                bcnt    <= '0;
                rd_mode <= 1'b0;
                sda_oe  <= 1'b0;
            end else begin
                case (st)
                    ST_RX: begin
                        if (ev.scl_rise && bcnt < 4'd8) begin
                            shreg <= {shreg[6:0], ev.sda};
                            bcnt  <= bcnt + 4'd1;
                        end else if (ev.scl_fall && bcnt == 4'd8) begin
                            case (ph)
                                PH_ADDR: if (rx_ack) begin
                                    rd_mode <= shreg[0];
                                    ph      <= PH_INDEX;
                                end
                                PH_INDEX: begin
                                    idx <= shreg;
                                    ph  <= PH_COUNT;
                                end
                                PH_COUNT: begin
                                    wrem <= shreg;
                                    ph   <= PH_DATA;
                                end
                                default: if (rx_ack) begin
                                    wr   <= '{en: 1'b1, idx: idx, data: shreg};
                                    idx  <= idx + 8'd1;
                                    wrem <= wrem - 8'd1;
                                end
                            endcase
                            st     <= rx_ack ? ST_RX_ACK : ST_SKIP;
                            sda_oe <= rx_ack;
                        end
                    end
                    ST_RX_ACK: if (ev.scl_fall) begin
                        bcnt <= '0;
                        if (rd_mode) begin
                            st     <= ST_TX;
                            txb    <= cnt_byte;
                            sda_oe <= ~cnt_byte[7];
                        end else begin
                            st     <= ST_RX;
                            sda_oe <= 1'b0;
                        end
                    end
                    ST_TX: begin
                        if (ev.scl_rise) begin
                            bcnt <= bcnt + 4'd1;
                        end else if (ev.scl_fall) begin
                            if (bcnt == 4'd8) begin
                                sda_oe <= 1'b0;
                                st     <= ST_TX_ACK;
                            end else begin
                                txb    <= {txb[6:0], 1'b0};
                                sda_oe <= ~txb[6];
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (ev.scl_rise) begin
                            hack <= ~ev.sda;
                        end else if (ev.scl_fall) begin
                            if (hack) begin
                                txb    <= rd_data;
                                sda_oe <= ~rd_data[7];
                                idx    <= idx + 8'd1;
                                bcnt   <= '0;
                                st     <= ST_TX;
                            end else begin
                                sda_oe <= 1'b0;
                                st     <= ST_SKIP;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE) |-> !sda_oe); // R6
    AST_SKIP_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SKIP) |-> !sda_oe); // R2
    AST_SDA_LOW_PHASE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $changed(sda_oe)) |-> $past(ev.scl_fall || ev.start || ev.stop)); // R12
endmodule

// File: tb/tb_smb_cfg_target.sv
module tb_smb_cfg_target;
    localparam int NREG = 9;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst = 1'b1;
    logic hscl = 1'b1, hsda = 1'b1;
    logic [1:0] a1 = 2'b00, a0 = 2'b00;
    logic [2:0] mode_rb = 3'b101;
    logic [7:0] pin_rb = 8'h5A;
    logic [8*NREG-1:0] cfg_q;
    logic sda_oe;
    wire  sda_line = hsda & ~sda_oe;

    smb_cfg_target dut (
        .clk(clk), .rst(rst), .scl_i(hscl), .sda_i(sda_line), .sda_oe(sda_oe),
        .strap_a1(a1), .strap_a0(a0), .mode_rb_i(mode_rb), .pin_rb_i(pin_rb), .cfg_q(cfg_q)
    );

    int checks = 0, errors = 0;
    bit busy = 1'b1;
    logic [7:0] m_rw [0:8];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] wmask(input int i);
        case (i)
            0: return 8'h38; 1: return 8'hFF; 2: return 8'hFF;
            4: return 8'h0E; 7: return 8'h1F; default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] exp_rd(input int i);
        if (i > 8) return 8'h00;
        case (i)
            0: return (m_rw[0] & 8'h38) | {mode_rb[2:1], 5'b0, mode_rb[0]};
            3: return pin_rb;
            5: return 8'h31;
            6: return 8'hDB;
            default: return m_rw[i];
        endcase
    endfunction

    function automatic logic [7:0] tb_addr(input int r1, input int r0);
        case (r1 * 3 + r0)
            0: return 8'hD8; 1: return 8'hDA; 2: return 8'hDE;
            3: return 8'hC2; 4: return 8'hC4; 5: return 8'hC6;
            6: return 8'hCA; 7: return 8'hCC; default: return 8'hCE;
        endcase
    endfunction

    function automatic logic [1:0] code_of(input int r);
        return (r == 0) ? 2'b00 : (r == 1) ? 2'b01 : 2'b10;
    endfunction

    task automatic mdl_reset();
        for (int i = 0; i < 9; i++) m_rw[i] = 8'h00;
        m_rw[0] = 8'h38; m_rw[1] = 8'hFF; m_rw[2] = 8'hFF; m_rw[7] = 8'h08;
    endtask

    task automatic mdl_write(input int i, input logic [7:0] d);
        if (i < 9) m_rw[i] = (m_rw[i] & ~wmask(i)) | (d & wmask(i));
    endtask

    // continuous model comparison while the bus is quiet
    always @(negedge clk) begin
        if (!rst && !busy) begin
            for (int i = 0; i < NREG; i++)
                chk(cfg_q[8*i +: 8] == exp_rd(i), "R3 model", cfg_q[8*i +: 8], exp_rd(i));
            chk(sda_oe == 1'b0, "R6 idle release", sda_oe, 0);
        end
    end

    // SDA drive must not change while SCL has been high
    int hi_cnt = 0;
    logic prev_oe = 1'b0;
    always @(negedge clk) begin
        hi_cnt = hscl ? hi_cnt + 1 : 0;
        if (!rst && sda_oe !== prev_oe) chk(hi_cnt < 2, "R12 sda change in scl high", hi_cnt, 0);
        prev_oe = sda_oe;
    end

    task automatic hw(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        hw(4); hsda = 1'b1; hw(4); hscl = 1'b1; hw(8); hsda = 1'b0; hw(8); hscl = 1'b0;
    endtask

    task automatic bus_stop();
        hw(4); hsda = 1'b0; hw(4); hscl = 1'b1; hw(8); hsda = 1'b1; hw(8);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            hw(4); hsda = b[i]; hw(4); hscl = 1'b1; hw(8); hscl = 1'b0;
        end
        hw(4); hsda = 1'b1; hw(4); hscl = 1'b1; hw(4); ack = !sda_line; hw(4); hscl = 1'b0;
    endtask

    task automatic recv_byte(input bit nack, output logic [7:0] b);
        hsda = 1'b1;
        b = 8'h00;
        for (int i = 0; i < 8; i++) begin
            hw(8); hscl = 1'b1; hw(4); b = {b[6:0], sda_line}; hw(4); hscl = 1'b0;
        end
        hw(4); hsda = nack; hw(4); hscl = 1'b1; hw(8); hscl = 1'b0;
    endtask

    task automatic blk_write(input logic [7:0] wa, input logic [7:0] n0, input logic [7:0] cnt,
                             input int nsend, input logic [7:0] base, input bit hit);
        bit ack;
        busy = 1'b1; hw(1);
        bus_start();
        send_byte(wa, ack);  chk(ack == hit, hit ? "R3 addr ack" : "R2 foreign addr", ack, hit);
        send_byte(n0, ack);  chk(ack == hit, hit ? "R3 index ack" : "R2 released", ack, hit);
        send_byte(cnt, ack); chk(ack == hit, hit ? "R3 count ack" : "R2 released", ack, hit);
        for (int k = 0; k < nsend; k++) begin
            send_byte(base + 8'(k * 8'h11), ack);
            if (!hit) chk(ack == 1'b0, "R2 released", ack, 0);
            else if (k < int'(cnt)) chk(ack == 1'b1, "R3 data ack", ack, 1);
            else chk(ack == 1'b0, "R4 extra byte nack", ack, 0);
        end
        bus_stop();
        if (hit) for (int k = 0; k < int'(cnt) && k < nsend; k++)
            mdl_write(int'(n0) + k, base + 8'(k * 8'h11));
        busy = 1'b0;
    endtask

    task automatic blk_read(input logic [7:0] wa, input logic [7:0] n0, input int nbytes);
        bit ack;
        logic [7:0] b;
        busy = 1'b1; hw(1);
        bus_start();
        send_byte(wa, ack); chk(ack, "R5 addr ack", ack, 1);
        send_byte(n0, ack); chk(ack, "R5 index ack", ack, 1);
        bus_start();
        send_byte(wa | 8'h01, ack); chk(ack, "R5 read addr ack", ack, 1);
        recv_byte(nbytes == 0, b);
        chk(b == {3'b000, m_rw[7][4:0]}, "R7 length byte", b, {3'b000, m_rw[7][4:0]});
        for (int k = 0; k < nbytes; k++) begin
            recv_byte(k == nbytes - 1, b);
            chk(b == exp_rd(int'(n0) + k), "R5 read data", b, exp_rd(int'(n0) + k));
        end
        hw(6);
        chk(sda_oe == 1'b0, "R6 release after nack", sda_oe, 0);
        bus_stop();
        busy = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        bit ack;
        mdl_reset();
        hw(5); rst = 1'b0; hw(2);
        // R11 reset state
        chk(cfg_q[15:8] == 8'hFF, "R11 reset idx1", cfg_q[15:8], 8'hFF);
        chk(cfg_q[23:16] == 8'hFF, "R11 reset idx2", cfg_q[23:16], 8'hFF);
        chk(cfg_q[63:56] == 8'h08, "R11 reset count", cfg_q[63:56], 8'h08);
        chk(sda_oe == 1'b0, "R11 sda released", sda_oe, 0);
        chk(cfg_q[7:0] == 8'hB9, "R10 idx0 layout", cfg_q[7:0], 8'hB9);
        busy = 1'b0;

        // R5 R7 R8: default read of all nine bytes
        blk_read(8'hD8, 8'd0, 9);
        // R3 plain write then read back
        blk_write(8'hD8, 8'd1, 8'd2, 2, 8'h12, 1'b1);
        blk_read(8'hD8, 8'd1, 2);
        // R8 R9 R10 masked write across 4..8
        blk_write(8'hD8, 8'd4, 8'd5, 5, 8'hA5, 1'b1);
        chk(cfg_q[63:56] == 8'h18, "R7 count written", cfg_q[63:56], 8'h18);
        chk(cfg_q[47:40] == 8'h31, "R8 idx5 unchanged", cfg_q[47:40], 8'h31);
        chk(cfg_q[55:48] == 8'hDB, "R8 idx6 unchanged", cfg_q[55:48], 8'hDB);
        chk(cfg_q[71:64] == 8'h00, "R9 idx8 zero", cfg_q[71:64], 8'h00);
        blk_read(8'hD8, 8'd0, 9);
        // R7 smaller count, R9 read past the end
        blk_write(8'hD8, 8'd7, 8'd1, 1, 8'h03, 1'b1);
        blk_read(8'hD8, 8'd6, 4);
        // R4 extra bytes after the count
        blk_write(8'hD8, 8'd0, 8'd1, 3, 8'hF0, 1'b1);
        chk(cfg_q[15:8] == 8'h12, "R4 idx1 untouched", cfg_q[15:8], 8'h12);
        // R9 out-of-range write
        blk_write(8'hD8, 8'd9, 8'd2, 2, 8'h77, 1'b1);
        blk_read(8'hD8, 8'd8, 3);

        // R1 R2 every strap setting, plus a neighbouring address
        for (int j = 0; j < 9; j++) begin
            busy = 1'b1; hw(1);
            a1 = code_of(j / 3); a0 = code_of(j % 3);
            hw(2); busy = 1'b0;
            blk_read(tb_addr(j / 3, j % 3), 8'd6, 1);
            busy = 1'b1; hw(1);
            bus_start();
            send_byte(tb_addr(((j + 1) % 9) / 3, ((j + 1) % 9) % 3), ack);
            chk(ack == 1'b0, "R1 R2 neighbour address", ack, 0);
            bus_stop();
            busy = 1'b0;
        end
        // R2 full foreign write leaves registers untouched
        busy = 1'b1; hw(1); a1 = 2'b01; a0 = 2'b01; hw(2); busy = 1'b0;
        blk_write(8'hD8, 8'd1, 8'd1, 2, 8'h00, 1'b0);
        blk_read(8'hC4, 8'd1, 2);

        // R10 live readback fields
        busy = 1'b1; hw(1);
        mode_rb = 3'b010; pin_rb = 8'hC3;
        hw(2); busy = 1'b0;
        blk_read(8'hC4, 8'd0, 4);

        // R11 reset in the middle of a transfer
        blk_write(8'hC4, 8'd2, 8'd1, 1, 8'h00, 1'b1);
        busy = 1'b1; hw(1);
        bus_start();
        send_byte(8'hC4, ack);
        for (int i = 0; i < 3; i++) begin
            hw(4); hsda = 1'b0; hw(4); hscl = 1'b1; hw(8); hscl = 1'b0;
        end
        rst = 1'b1; hw(3); rst = 1'b0; mdl_reset(); hw(1);
        chk(sda_oe == 1'b0, "R11 release on reset", sda_oe, 0);
        chk(cfg_q[23:16] == 8'hFF, "R11 idx2 default", cfg_q[23:16], 8'hFF);
        chk(cfg_q[63:56] == 8'h08, "R11 count default", cfg_q[63:56], 8'h08);
        bus_stop();
        busy = 1'b0;
        blk_read(8'hC4, 8'd0, 9);

        hw(20);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule